// File: doc/BRIEF.md
# Local/Remote Control Selector

This block decides where an instrument's eight control lines come from: the front-panel switches or a remote interface connector. The lines form two groups of four, and each group has its own two-way selector. All groups share one select. The select input is active low. When it is high or left floating, the front panel is in charge and the remote lines are ignored. When it is pulled to ground, the remote lines take over. The remote lines use ground-true logic and sit high through pull-ups when nothing drives them. The block inverts them, so the `ctrl` bus is active high whatever the source.

Selecting remote also sends a hold command (`hold_n` low) to the measurement section. The hold stops free-running sampling, so readings must then be triggered from outside. A configuration strap, `keep_panel`, keeps the front panel in charge of the control lines while remote is selected. With the strap fitted, the remote lines stay disabled but the hold is still asserted, so external triggering remains usable.

The select input passes through a synchronizer. Both outputs come from registers, so they change only on a rising clock edge.

Top module: `lr_ctrl_select`

## Requirements
- R1: While reset is asserted, `ctrl` is all zeros and `hold_n` is 1.
- R2: In local mode (synchronized `local_remote_n` = 1), `ctrl` equals `panel` one clock edge after `panel` is sampled.
- R3: In remote mode (synchronized `local_remote_n` = 0) with `keep_panel` = 0, bit i of `ctrl` is the inverse of bit i of `remote_n`, one edge after sampling.
- R4: In remote mode, a remote bit held at 1 (undriven, pulled up) reads as 0 on `ctrl`; all-ones `remote_n` gives `ctrl` = 0x00.
- R5: `hold_n` is 0 exactly when the synchronized select is remote, and 1 in local mode; `keep_panel` has no effect on it.
- R6: In remote mode with `keep_panel` = 1, `ctrl` follows `panel` while `hold_n` stays 0.
- R7: A change on `local_remote_n` reaches `ctrl` and `hold_n` on the third rising edge after it is applied (two synchronizer stages plus the output register), and not earlier.
- R8: In local mode, `remote_n` has no effect on `ctrl`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| panel | input | 8 | Front-panel control switches, active high |
| remote_n | input | 8 | Remote control lines, ground-true, pulled up when idle |
| local_remote_n | input | 1 | Source select: 1 = local (front panel), 0 = remote |
| keep_panel | input | 1 | Strap: keep the front panel in charge while remote is selected |
| ctrl | output | 8 | Selected control lines, active high |
| hold_n | output | 1 | Hold command to the meters, active low |

## Verification
The checker keeps its own delayed copy of the select. On every cycle it checks the data path for each mode: panel passthrough, inverted remote lines, and strap override. It also checks the hold output against the mode, and the reset values. The bench scenarios cover the rest. They show the exact edge on which a mode change appears. They show that the outputs do not move before that edge. They show that idle remote lines read as inactive, and that remote activity is invisible in local mode.

// File: rtl/lr_sel_pkg.sv
package lr_sel_pkg;
   typedef enum logic {
      SRC_PANEL  = 1'b0,
      SRC_REMOTE = 1'b1
   } ctrl_src_e;

   localparam int unsigned MIN_SYNC_STAGES = 2;
endpackage

// File: rtl/lr_sync.sv
module lr_sync #(
   parameter int unsigned STAGES    = 2,
   parameter logic        RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   localparam int unsigned LAST = STAGES - 1;

   if (STAGES < lr_sel_pkg::MIN_SYNC_STAGES) begin : g_bad_stages
      $error("lr_sync: STAGES must be at least %0d", lr_sel_pkg::MIN_SYNC_STAGES);
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[LAST];
endmodule

// File: rtl/lr_mux_group.sv
module lr_mux_group
   import lr_sel_pkg::*;
#(
   parameter int unsigned W                 = 4,
   parameter bit          REMOTE_ACTIVE_LOW = 1'b1
) (
   input  logic [W-1:0] panel_i,
   input  logic [W-1:0] remote_i,
   input  ctrl_src_e    src_i,
   output logic [W-1:0] sel_o
);
   logic [W-1:0] remote_hi;

   if (REMOTE_ACTIVE_LOW) begin : g_invert
      assign remote_hi = ~remote_i;
   end else begin : g_direct
      assign remote_hi = remote_i;
   end

   always_comb begin
      unique case (src_i)
         SRC_REMOTE: sel_o = remote_hi;
         default:    sel_o = panel_i;
      endcase
   end
endmodule

// File: rtl/lr_ctrl_select.sv
module lr_ctrl_select
   import lr_sel_pkg::*;
#(
   parameter int unsigned GROUP_W           = 4,
   parameter int unsigned NUM_GROUPS        = 2,
   parameter int unsigned SYNC_STAGES       = 2,
   parameter bit          REMOTE_ACTIVE_LOW = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [GROUP_W*NUM_GROUPS-1:0] panel,
   input  logic [GROUP_W*NUM_GROUPS-1:0] remote_n,
   input  logic                          local_remote_n,
   input  logic                          keep_panel,
   output logic [GROUP_W*NUM_GROUPS-1:0] ctrl,
   output logic                          hold_n
);
   localparam int unsigned LINES = GROUP_W * NUM_GROUPS;

   if (GROUP_W == 0 || NUM_GROUPS == 0) begin : g_bad_shape
      $error("lr_ctrl_select: GROUP_W and NUM_GROUPS must be non-zero");
   end

   logic         sel_local_s;
   logic         remote_req;
   ctrl_src_e    src;
   logic [LINES-1:0] ctrl_d;

   lr_sync #(
      .STAGES    (SYNC_STAGES),
      .RESET_VAL (1'b1)
   ) u_sel_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (local_remote_n),
      .q     (sel_local_s)
   );

   assign remote_req = ~sel_local_s;
   assign src        = (remote_req && !keep_panel) ? SRC_REMOTE : SRC_PANEL;

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_group
      lr_mux_group #(
         .W                 (GROUP_W),
         .REMOTE_ACTIVE_LOW (REMOTE_ACTIVE_LOW)
      ) u_mux (
         .panel_i  (panel[g*GROUP_W +: GROUP_W]),
         .remote_i (remote_n[g*GROUP_W +: GROUP_W]),
         .src_i    (src),
         .sel_o    (ctrl_d[g*GROUP_W +: GROUP_W])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl   <= '0;
         hold_n <= 1'b1;
      end else begin
         ctrl   <= ctrl_d;
         hold_n <= ~remote_req;
      end
   end
endmodule

// File: rtl/lr_ctrl_select_chk.sv
module lr_ctrl_select_chk #(
   parameter int unsigned W                 = 8,
   parameter int unsigned SYNC_STAGES       = 2,
   parameter bit          REMOTE_ACTIVE_LOW = 1'b1
) (
   input logic         clk,
   input logic         rst_n,
   input logic [W-1:0] panel,
   input logic [W-1:0] remote_n,
   input logic         local_remote_n,
   input logic         keep_panel,
   input logic [W-1:0] ctrl,
   input logic         hold_n
);
   logic [SYNC_STAGES-1:0] sel_dly;
   logic                   in_reset_q;
   logic                   mode_local;
   logic [W-1:0]           remote_hi;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sel_dly <= '1;
      else        sel_dly <= {sel_dly[SYNC_STAGES-2:0], local_remote_n};
   end

   always_ff @(posedge clk) in_reset_q <= !rst_n;

   assign mode_local = sel_dly[SYNC_STAGES-1];
   assign remote_hi  = REMOTE_ACTIVE_LOW ? ~remote_n : remote_n;

   // R1: reset values once reset has been seen on an edge
   p_reset_vals_r1: assert property (@(posedge clk)
      (!rst_n && in_reset_q) |-> (ctrl == '0 && hold_n));

   // R2 and R8: local mode passes the panel through
   p_local_panel_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mode_local |=> (ctrl == $past(panel)));

   // R3 and R4: remote mode drives the inverted remote lines
   p_remote_lines_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_local && !keep_panel) |=> (ctrl == $past(remote_hi)));

   // R5: hold follows the synchronized mode
   p_hold_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (hold_n == $past(mode_local)));

   // R6: strap keeps the panel in charge while hold stays asserted
   p_strap_panel_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_local && keep_panel) |=> (ctrl == $past(panel) && !hold_n));
endmodule

bind lr_ctrl_select lr_ctrl_select_chk #(
   .W                 (GROUP_W * NUM_GROUPS),
   .SYNC_STAGES       (SYNC_STAGES),
   .REMOTE_ACTIVE_LOW (REMOTE_ACTIVE_LOW)
) u_chk (.*);

// File: tb/tb_lr_ctrl_select.sv
module tb_lr_ctrl_select;
   localparam int CLK_PERIOD = 10;
   localparam int W          = 8;
   localparam int SETTLE     = 3;   // two sync stages + output register
   localparam int NVEC       = 8;

   // {lr_n, keep, panel, remote_n, exp_ctrl, exp_hold_n, req}
   typedef struct packed {
      logic       lr_n;
      logic       keep;
      logic [7:0] pnl;
      logic [7:0] rmt;
      logic [7:0] exp_ctrl;
      logic       exp_hold;
      logic [3:0] req;
   } vec_t;

   localparam vec_t VECS [NVEC] = '{
      '{1'b1, 1'b0, 8'hA5, 8'h00, 8'hA5, 1'b1, 4'd2},  // R2 local passthrough
      '{1'b1, 1'b0, 8'h3C, 8'hFF, 8'h3C, 1'b1, 4'd8},  // R8 remote ignored
      '{1'b0, 1'b0, 8'h5A, 8'hF0, 8'h0F, 1'b0, 4'd3},  // R3 remote inverted
      '{1'b0, 1'b0, 8'h5A, 8'hFF, 8'h00, 1'b0, 4'd4},  // R4 idle lines read 0
      '{1'b0, 1'b1, 8'hC3, 8'h00, 8'hC3, 1'b0, 4'd6},  // R6 strap keeps panel
      '{1'b0, 1'b0, 8'hC3, 8'h7E, 8'h81, 1'b0, 4'd3},  // R3 mixed pattern
      '{1'b1, 1'b1, 8'h96, 8'h00, 8'h96, 1'b1, 4'd5},  // R5 strap alone, no hold
      '{1'b0, 1'b0, 8'hFF, 8'hA5, 8'h5A, 1'b0, 4'd5}   // R5 hold in remote
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] panel = '0;
   logic [W-1:0] remote_n = '1;
   logic         local_remote_n = 1'b1;
   logic         keep_panel = 1'b0;
   logic [W-1:0] ctrl;
   logic         hold_n;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lr_ctrl_select dut (
      .clk            (clk),
      .rst_n          (rst_n),
      .panel          (panel),
      .remote_n       (remote_n),
      .local_remote_n (local_remote_n),
      .keep_panel     (keep_panel),
      .ctrl           (ctrl),
      .hold_n         (hold_n)
   );

   task automatic check(input string req, input logic [W-1:0] exp_c, input logic exp_h);
      n_checks++;
      if (ctrl !== exp_c || hold_n !== exp_h) begin
         n_fail++;
         $display("FAIL %s: ctrl=%02h hold_n=%0b expected ctrl=%02h hold_n=%0b",
                  req, ctrl, hold_n, exp_c, exp_h);
      end
   endtask

   task automatic edges(input int n);
      for (int i = 0; i < n; i++) @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      edges(3);
      check("R1", 8'h00, 1'b1);                     // R1 reset values
      panel = 8'hFF; remote_n = 8'h00; local_remote_n = 1'b0;
      edges(2);
      check("R1", 8'h00, 1'b1);                     // R1 inputs ignored in reset
      rst_n = 1'b1; local_remote_n = 1'b1;
      edges(SETTLE);

      for (int v = 0; v < NVEC; v++) begin
         local_remote_n = VECS[v].lr_n;
         keep_panel     = VECS[v].keep;
         panel          = VECS[v].pnl;
         remote_n       = VECS[v].rmt;
         edges(SETTLE);
         check($sformatf("R%0d vec%0d", VECS[v].req, v), VECS[v].exp_ctrl, VECS[v].exp_hold);
      end

      // R2: panel data appears one edge later, not before
      local_remote_n = 1'b1; keep_panel = 1'b0; panel = 8'h11;
      edges(SETTLE);
      panel = 8'h22;
      #1 check("R2 before edge", 8'h11, 1'b1);
      edges(1);
      check("R2 one edge", 8'h22, 1'b1);

      // R8: remote toggling in local mode stays invisible
      remote_n = 8'h00; edges(1);
      check("R8 remote low", 8'h22, 1'b1);
      remote_n = 8'h5A; edges(1);
      check("R8 remote mixed", 8'h22, 1'b1);

      // R7: mode change latency, local -> remote
      remote_n = 8'hF0;
      local_remote_n = 1'b0;
      edges(2);
      check("R7 remote edge2", 8'h22, 1'b1);
      edges(1);
      check("R7 remote edge3", 8'h0F, 1'b0);

      // R7: remote -> local
      local_remote_n = 1'b1;
      edges(2);
      check("R7 local edge2", 8'h0F, 1'b0);
      edges(1);
      check("R7 local edge3", 8'h22, 1'b1);

      // R6: strap flips output source without moving hold
      local_remote_n = 1'b0; edges(SETTLE);
      keep_panel = 1'b1; edges(1);
      check("R6 strap on", 8'h22, 1'b0);
      keep_panel = 1'b0; edges(1);
      check("R6 strap off", 8'h0F, 1'b0);

      // R1: asynchronous reset mid-run
      rst_n = 1'b0; #1;
      check("R1 async", 8'h00, 1'b1);

      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (2000) @(posedge clk);
            n_checks++; n_fail++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         end
      join_any
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end
endmodule